// File: doc/BRIEF.md
# Position-decoder event conditioning and routing

This block joins a position-decoder counter core to the chip's event fabric. It holds one 16-bit event-control word. That word conditions three asynchronous incoming event lines and gates the core's status signals onto outgoing event lines. Each incoming line is synchronized and can be inverted. When its enable is set, the line yields one single-cycle pulse per active edge. In counter-only operating mode, with the action field set to count, those pulses become count requests for the core.

On the output side, several core signals each have their own enable and are passed to the event fabric:

- compare matches on two channels, as pulses;
- overflow/underflow, as a pulse;
- error, as a pulse;
- rotation direction, as a level;
- velocity, as a pulse on every change of the qualified phase pair; this output is suppressed in counter-only mode.

The control word can be written only while the peripheral is disabled. A write made while the peripheral is enabled is discarded and flagged for one cycle.

Top module: `qdec_event_ctrl`

## Requirements
- R1: After reset the control word reads 0 and every event output and the write-error flag are 0.
- R2: A write with periph_en = 0 stores cfg_wdata[13:0] and is visible on cfg_rdata one cycle later. cfg_rdata[15:14] always read 0. The field layout is:
  - bits 1:0: action;
  - bits 4:2: invert for channels 0..2;
  - bits 7:5: enable for channels 0..2;
  - bit 8: overflow;
  - bit 9: error;
  - bit 10: direction;
  - bit 11: velocity;
  - bits 13:12: match channels 0..1.
- R3: A write with periph_en = 1 leaves the control word unchanged and drives cfg_wr_err high for exactly the following cycle. An accepted write leaves cfg_wr_err low.
- R4: evt_in[n] passes through a two-flop synchronizer. With enable bit 5+n set and invert bit 2+n clear, each rising edge of evt_in[n] gives a one-cycle pulse on chan_evt_o[n], three clock edges after the input changes. With the enable bit clear, no pulse is produced.
- R5: With invert bit 2+n set, the channel pulses on falling edges of evt_in[n] instead of rising edges. Changing the invert bit on its own produces no pulse.
- R6: count_evt_o pulses in the same cycle as any chan_evt_o pulse only when op_mode = 2 (counter-only) and the action field = 2 (count). Action codes 0, 1 and 3, and all other modes, give no count pulse.
- R7: match_evt_o[m], ovf_evt_o and err_evt_o each equal their core input ANDed with its enable bit, delayed by one cycle. For single-cycle inputs the output is one cycle wide.
- R8: dir_evt_o follows dir_in with a one-cycle delay while bit 10 is set, and is 0 while it is clear.
- R9: vel_evt_o pulses for one cycle, one cycle after any change of phase_in, when bit 11 is set and op_mode is not 2. Otherwise it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| periph_en | input | 1 | Peripheral enable; locks the control word when high |
| op_mode | input | 2 | Operating mode; 2 = counter-only |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word write data |
| cfg_rdata | output | 16 | Control word readback |
| cfg_wr_err | output | 1 | One-cycle flag for a rejected write |
| evt_in | input | 3 | Asynchronous incoming event lines |
| phase_in | input | 2 | Qualified decoder phases from the core |
| match_in | input | 2 | Compare-match pulses from the core |
| ovf_in | input | 1 | Overflow/underflow pulse from the core |
| err_in | input | 1 | Error pulse from the core |
| dir_in | input | 1 | Rotation direction level from the core |
| chan_evt_o | output | 3 | Qualified per-channel input event pulses |
| count_evt_o | output | 1 | Count request pulse to the core |
| match_evt_o | output | 2 | Gated compare-match events |
| ovf_evt_o | output | 1 | Gated overflow/underflow event |
| err_evt_o | output | 1 | Gated error event |
| dir_evt_o | output | 1 | Gated direction level |
| vel_evt_o | output | 1 | Gated velocity event |

## Verification
The properties assume that the core's signals (match_in, ovf_in, err_in, dir_in, phase_in) are synchronous to clk. They also assume that op_mode changes only together with a reconfiguration. The bench therefore drives every core input at the falling edge. It keeps op_mode and the control word fixed throughout each random run and changes them only in idle gaps with all inputs low. The incoming event lines are toggled at random falling edges. Each toggle is held for at least one cycle, so every edge survives the synchronizer and the bench model can predict the pulse three edges later.

// File: rtl/qdec_evt_pkg.sv
package qdec_evt_pkg;

    localparam int N_CH        = 3;
    localparam int N_MATCH     = 2;
    localparam int N_PHASE     = 2;
    localparam int CFG_W       = 16;
    localparam int MODE_W      = 2;
    localparam int ACT_W       = 2;

    localparam int ACT_LSB     = 0;
    localparam int INV_LSB     = ACT_LSB + ACT_W;
    localparam int EN_LSB      = INV_LSB + N_CH;
    localparam int OVF_BIT     = EN_LSB + N_CH;
    localparam int ERR_BIT     = OVF_BIT + 1;
    localparam int DIR_BIT     = ERR_BIT + 1;
    localparam int VEL_BIT     = DIR_BIT + 1;
    localparam int MATCH_LSB   = VEL_BIT + 1;
    localparam int USED_W      = MATCH_LSB + N_MATCH;

    typedef enum logic [ACT_W-1:0] {
        ACT_OFF   = 2'd0,
        ACT_RSVD1 = 2'd1,
        ACT_COUNT = 2'd2,
        ACT_RSVD3 = 2'd3
    } act_e;

    typedef enum logic [MODE_W-1:0] {
        MODE_QUAD    = 2'd0,
        MODE_HALL    = 2'd1,
        MODE_COUNTER = 2'd2,
        MODE_SPARE   = 2'd3
    } mode_e;

    // Packed MSB first, so the field order equals the bit layout.
    typedef struct packed {
        logic [N_MATCH-1:0] match_en;
        logic               vel_en;
        logic               dir_en;
        logic               err_en;
        logic               ovf_en;
        logic [N_CH-1:0]    in_en;
        logic [N_CH-1:0]    in_inv;
        act_e               act;
    } cfg_t;

endpackage

// File: rtl/evt_cfg_reg.sv
module evt_cfg_reg
    import qdec_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             periph_en,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output cfg_t             cfg,
    output logic [CFG_W-1:0] cfg_rdata,
    output logic             cfg_wr_err
);

    typedef struct packed {
        cfg_t cfg;
        logic wr_err;
    } reg_st_t;

    reg_st_t s_d, s_q;

    logic unused_wdata_hi;
    assign unused_wdata_hi = ^cfg_wdata[CFG_W-1:USED_W];

    always_comb begin
        s_d        = s_q;
        s_d.wr_err = 1'b0;
        if (cfg_we) begin
            if (periph_en) begin
                s_d.wr_err = 1'b1;
            end else begin
                s_d.cfg = cfg_t'(cfg_wdata[USED_W-1:0]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cfg        = s_q.cfg;
    assign cfg_rdata  = {{(CFG_W-USED_W){1'b0}}, s_q.cfg};
    assign cfg_wr_err = s_q.wr_err;

    AST_WR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && periph_en) |=> $stable(cfg_rdata)); // R3
    AST_WR_ERR_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && periph_en) |=> cfg_wr_err); // R3
    AST_WR_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_err |-> $past(cfg_we && periph_en)); // R3
    AST_WR_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !periph_en) |=> (cfg_rdata[USED_W-1:0] == $past(cfg_wdata[USED_W-1:0]))); // R2

endmodule

// File: rtl/evt_in_cond.sv
module evt_in_cond
    import qdec_evt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] evt_in,
    input  logic [N_CH-1:0] in_en,
    input  logic [N_CH-1:0] in_inv,
    input  act_e            act,
    input  logic            counting,
    output logic [N_CH-1:0] chan_evt,
    output logic            count_evt
);

    localparam int LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0][N_CH-1:0] sync;
        logic [N_CH-1:0]                  prev;
        logic [N_CH-1:0]                  chan;
        logic                             cnt;
    } in_st_t;

    in_st_t s_d, s_q;

    logic [N_CH-1:0] raw;
    logic [N_CH-1:0] hit;

    assign raw = s_q.sync[LAST];

    // The invert bit is applied to both the current and the previous sample,
    // so a change of the invert bit alone never forms an edge.
    for (genvar n = 0; n < N_CH; n++) begin : g_chan
        logic cur_lvl;
        logic old_lvl;
        assign cur_lvl = raw[n] ^ in_inv[n];
        assign old_lvl = s_q.prev[n] ^ in_inv[n];
        assign hit[n]  = in_en[n] & cur_lvl & ~old_lvl;

        AST_CHAN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
            chan_evt[n] |=> !chan_evt[n]); // R4
        AST_CHAN_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
            chan_evt[n] |-> $past(in_en[n])); // R4
    end

    always_comb begin
        s_d         = s_q;
        s_d.sync[0] = evt_in;
        for (int s = 1; s < SYNC_STAGES; s++) begin
            s_d.sync[s] = s_q.sync[s-1];
        end
        s_d.prev = raw;
        s_d.chan = hit;
        s_d.cnt  = (|hit) && counting && (act == ACT_COUNT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign chan_evt  = s_q.chan;
    assign count_evt = s_q.cnt;

    AST_CNT_HAS_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
        count_evt |-> (|chan_evt)); // R6
    AST_CNT_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        count_evt |-> $past(counting && (act == ACT_COUNT))); // R6

endmodule

// File: rtl/evt_out_gate.sv
module evt_out_gate
    import qdec_evt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_MATCH-1:0] match_in,
    input  logic               ovf_in,
    input  logic               err_in,
    input  logic               dir_in,
    input  logic [N_PHASE-1:0] phase_in,
    input  logic [N_MATCH-1:0] match_en,
    input  logic               ovf_en,
    input  logic               err_en,
    input  logic               dir_en,
    input  logic               vel_en,
    input  logic               counting,
    output logic [N_MATCH-1:0] match_evt,
    output logic               ovf_evt,
    output logic               err_evt,
    output logic               dir_evt,
    output logic               vel_evt
);

    typedef struct packed {
        logic [N_MATCH-1:0] match;
        logic               ovf;
        logic               err;
        logic               dir;
        logic               vel;
        logic [N_PHASE-1:0] phase_prev;
    } out_st_t;

    out_st_t s_d, s_q;

    logic [N_MATCH-1:0] match_g;

    for (genvar m = 0; m < N_MATCH; m++) begin : g_match
        assign match_g[m] = match_in[m] & match_en[m];

        AST_MATCH_GATE: assert property (@(posedge clk) disable iff (!rst_n)
            match_evt[m] |-> $past(match_in[m] && match_en[m])); // R7
    end

    always_comb begin
        s_d            = s_q;
        s_d.match      = match_g;
        s_d.ovf        = ovf_in & ovf_en;
        s_d.err        = err_in & err_en;
        s_d.dir        = dir_in & dir_en;
        s_d.vel        = vel_en && !counting && (phase_in != s_q.phase_prev);
        s_d.phase_prev = phase_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign match_evt = s_q.match;
    assign ovf_evt   = s_q.ovf;
    assign err_evt   = s_q.err;
    assign dir_evt   = s_q.dir;
    assign vel_evt   = s_q.vel;

    AST_OVF_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |-> $past(ovf_in && ovf_en)); // R7
    AST_ERR_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        err_evt |-> $past(err_in && err_en)); // R7
    AST_DIR_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        dir_evt |-> $past(dir_in && dir_en)); // R8
    AST_VEL_NOT_COUNTER: assert property (@(posedge clk) disable iff (!rst_n)
        vel_evt |-> $past(!counting && vel_en)); // R9

endmodule

// File: rtl/qdec_event_ctrl.sv
module qdec_event_ctrl
    import qdec_evt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               periph_en,
    input  logic [MODE_W-1:0]  op_mode,
    input  logic               cfg_we,
    input  logic [CFG_W-1:0]   cfg_wdata,
    output logic [CFG_W-1:0]   cfg_rdata,
    output logic               cfg_wr_err,
    input  logic [N_CH-1:0]    evt_in,
    input  logic [N_PHASE-1:0] phase_in,
    input  logic [N_MATCH-1:0] match_in,
    input  logic               ovf_in,
    input  logic               err_in,
    input  logic               dir_in,
    output logic [N_CH-1:0]    chan_evt_o,
    output logic               count_evt_o,
    output logic [N_MATCH-1:0] match_evt_o,
    output logic               ovf_evt_o,
    output logic               err_evt_o,
    output logic               dir_evt_o,
    output logic               vel_evt_o
);

    cfg_t cfg;
    logic counting;

    assign counting = (mode_e'(op_mode) == MODE_COUNTER);

    evt_cfg_reg i_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .periph_en  (periph_en),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .cfg        (cfg),
        .cfg_rdata  (cfg_rdata),
        .cfg_wr_err (cfg_wr_err)
    );

    evt_in_cond #(
        .SYNC_STAGES (SYNC_STAGES)
    ) i_in (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_in    (evt_in),
        .in_en     (cfg.in_en),
        .in_inv    (cfg.in_inv),
        .act       (cfg.act),
        .counting  (counting),
        .chan_evt  (chan_evt_o),
        .count_evt (count_evt_o)
    );

    evt_out_gate i_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .match_in  (match_in),
        .ovf_in    (ovf_in),
        .err_in    (err_in),
        .dir_in    (dir_in),
        .phase_in  (phase_in),
        .match_en  (cfg.match_en),
        .ovf_en    (cfg.ovf_en),
        .err_en    (cfg.err_en),
        .dir_en    (cfg.dir_en),
        .vel_en    (cfg.vel_en),
        .counting  (counting),
        .match_evt (match_evt_o),
        .ovf_evt   (ovf_evt_o),
        .err_evt   (err_evt_o),
        .dir_evt   (dir_evt_o),
        .vel_evt   (vel_evt_o)
    );

endmodule

// File: tb/test_qdec_event_ctrl.sv
`timescale 1ns/1ps
module test_qdec_event_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        periph_en = 1'b0;
    logic [1:0]  op_mode = 2'd0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        cfg_wr_err;
    logic [2:0]  evt_in = '0;
    logic [1:0]  phase_in = '0;
    logic [1:0]  match_in = '0;
    logic        ovf_in = 1'b0;
    logic        err_in = 1'b0;
    logic        dir_in = 1'b0;
    logic [2:0]  chan_evt_o;
    logic        count_evt_o;
    logic [1:0]  match_evt_o;
    logic        ovf_evt_o;
    logic        err_evt_o;
    logic        dir_evt_o;
    logic        vel_evt_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    qdec_event_ctrl i_qdec_event_ctrl (
        .clk(clk), .rst_n(rst_n), .periph_en(periph_en), .op_mode(op_mode),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .cfg_wr_err(cfg_wr_err), .evt_in(evt_in), .phase_in(phase_in),
        .match_in(match_in), .ovf_in(ovf_in), .err_in(err_in), .dir_in(dir_in),
        .chan_evt_o(chan_evt_o), .count_evt_o(count_evt_o),
        .match_evt_o(match_evt_o), .ovf_evt_o(ovf_evt_o), .err_evt_o(err_evt_o),
        .dir_evt_o(dir_evt_o), .vel_evt_o(vel_evt_o)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Control word built from the field layout of R2.
    function automatic logic [15:0] mk_cfg(input logic [1:0] mev, input logic vel,
                                           input logic dir, input logic err,
                                           input logic ovf, input logic [2:0] en,
                                           input logic [2:0] inv, input logic [1:0] act);
        return {2'b00, mev, vel, dir, err, ovf, en, inv, act};
    endfunction

    // R4/R5 model: channel pulse from the synchronized sample and the one before it.
    function automatic logic [2:0] exp_chan(input logic [2:0] cur, input logic [2:0] old,
                                            input logic [2:0] en, input logic [2:0] inv);
        return en & (cur ^ inv) & ~(old ^ inv);
    endfunction

    task automatic idle(input int n);
        evt_in = '0; phase_in = '0; match_in = '0;
        ovf_in = 1'b0; err_in = 1'b0; dir_in = 1'b0; cfg_we = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic write_cfg(input logic [15:0] data, input logic pen);
        cfg_we = 1'b1; cfg_wdata = data; periph_en = pen;
        @(negedge clk);
        cfg_we = 1'b0; periph_en = 1'b0;
    endtask

    task automatic run_random(input logic [15:0] cfg, input logic [1:0] mode, input int n);
        logic [2:0] eh [0:3];
        logic [1:0] ph_prev;
        logic [2:0] ec;
        logic       cnt_exp;
        logic [1:0] mexp;
        for (int i = 0; i < 4; i++) eh[i] = '0;
        ph_prev = '0;
        op_mode = mode;
        write_cfg(cfg, 1'b0);
        idle(4);
        periph_en = 1'b1;
        for (int i = 0; i < n; i++) begin
            for (int b = 0; b < 3; b++) begin
                if ($urandom_range(0, 3) == 0) evt_in[b] = ~evt_in[b];
            end
            if ($urandom_range(0, 2) == 0) phase_in = 2'($urandom_range(0, 3));
            match_in = 2'($urandom_range(0, 3));
            ovf_in   = 1'($urandom_range(0, 1));
            err_in   = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 4) == 0) dir_in = ~dir_in;
            eh[3] = eh[2]; eh[2] = eh[1]; eh[1] = eh[0]; eh[0] = evt_in;
            @(negedge clk);
            ec = exp_chan(eh[2], eh[3], cfg[7:5], cfg[4:2]);
            cnt_exp = (|ec) && (mode == 2'd2) && (cfg[1:0] == 2'd2);
            mexp = match_in & cfg[13:12];
            chk("R4/R5 chan_evt_o", 16'(chan_evt_o), 16'(ec));
            chk("R6 count_evt_o", 16'(count_evt_o), 16'(cnt_exp));
            chk("R7 match_evt_o", 16'(match_evt_o), 16'(mexp));
            chk("R7 ovf_evt_o", 16'(ovf_evt_o), 16'(ovf_in & cfg[8]));
            chk("R7 err_evt_o", 16'(err_evt_o), 16'(err_in & cfg[9]));
            chk("R8 dir_evt_o", 16'(dir_evt_o), 16'(dir_in & cfg[10]));
            chk("R9 vel_evt_o", 16'(vel_evt_o),
                16'(cfg[11] && (mode != 2'd2) && (phase_in != ph_prev)));
            ph_prev = phase_in;
        end
        periph_en = 1'b0;
        idle(6);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 cfg_rdata", cfg_rdata, 16'h0000);
        chk("R1 outputs", 16'({chan_evt_o, count_evt_o, match_evt_o, ovf_evt_o,
                               err_evt_o, dir_evt_o, vel_evt_o, cfg_wr_err}), 16'h0);

        // R2 write while disabled, unused bits read 0
        write_cfg(16'hFFFF, 1'b0);
        chk("R2 readback", cfg_rdata, 16'h3FFF);
        chk("R3 no error on accepted write", 16'(cfg_wr_err), 16'h0);
        write_cfg(16'h1234, 1'b0);
        chk("R2 readback second", cfg_rdata, 16'h1234);

        // R3 locked write
        write_cfg(16'h0000, 1'b1);
        chk("R3 locked write dropped", cfg_rdata, 16'h1234);
        chk("R3 wr_err raised", 16'(cfg_wr_err), 16'h1);
        @(negedge clk);
        chk("R3 wr_err one cycle", 16'(cfg_wr_err), 16'h0);

        // R5: changing inversion alone gives no pulse; disabled channel ignored (R4)
        evt_in = 3'b000;
        write_cfg(mk_cfg(2'b00, 0, 0, 0, 0, 3'b111, 3'b000, 2'd2), 1'b0);
        op_mode = 2'd2;
        idle(4);
        write_cfg(mk_cfg(2'b00, 0, 0, 0, 0, 3'b111, 3'b111, 2'd2), 1'b0);
        repeat (4) begin
            @(negedge clk);
            chk("R5 invert change no pulse", 16'(chan_evt_o), 16'h0);
        end
        write_cfg(mk_cfg(2'b00, 0, 0, 0, 0, 3'b000, 3'b000, 2'd2), 1'b0);
        evt_in = 3'b111;
        repeat (5) begin
            @(negedge clk);
            chk("R4 disabled channel ignored", 16'({chan_evt_o, count_evt_o}), 16'h0);
        end
        idle(6);

        // Random runs across configurations and modes
        run_random(mk_cfg(2'b11, 1, 1, 1, 1, 3'b111, 3'b000, 2'd2), 2'd2, 300); // R6 count active
        run_random(mk_cfg(2'b01, 1, 1, 0, 1, 3'b011, 3'b101, 2'd2), 2'd2, 300); // R5 inverted
        run_random(mk_cfg(2'b10, 1, 0, 1, 0, 3'b111, 3'b010, 2'd1), 2'd2, 300); // R6 reserved 1
        run_random(mk_cfg(2'b11, 1, 1, 1, 1, 3'b110, 3'b000, 2'd3), 2'd0, 300); // R6 reserved 3
        run_random(mk_cfg(2'b11, 1, 1, 1, 1, 3'b111, 3'b100, 2'd2), 2'd0, 300); // R6/R9 other mode
        run_random(mk_cfg(2'b00, 0, 0, 0, 0, 3'b000, 3'b000, 2'd0), 2'd1, 300); // R7/R8 all off

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule